// File: doc/BRIEF.md
# Dual-strobe presettable up/down counter

This block is a small binary counter, four bits wide by default, that wraps around at its maximum value. It has no direction pin. It has two strobe inputs instead: a rising edge on one strobe moves the count up by one, and a rising edge on the other moves it down by one. A level-sensitive, active-low load input copies a preset word into the count, which makes divide-by-N use possible. A level-sensitive, active-high clear input forces the count to zero and overrides the load.

Each strobe is an ordinary data input. A free-running system clock samples it through a two-flop synchronizer, and an edge detector finds its rising edges. The whole design is therefore a single synchronous clock domain.

There are two active-low terminal outputs, one for each direction:
- The carry output goes low while the count is at its maximum and the up strobe is in its low phase.
- The borrow output goes low while the count is zero and the down strobe is in its low phase.

A wider up/down counter is built by chaining stages. Each stage's carry output drives the next stage's up strobe, and its borrow output drives the next stage's down strobe. The rising edge at the end of each terminal pulse then steps the next stage.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `up_strobe` while `dn_strobe` stays high increments `count` by one.
- R2: A rising edge on `dn_strobe` while `up_strobe` stays high decrements `count` by one.
- R3: While `load_n` is low, `count` equals `preset`. Strobe edges during that time do not change it.
- R4: While `clear` is high, `count` is zero, whatever the strobes or `load_n` do.
- R5: Counting wraps modulo 2^WIDTH: up from all ones gives zero, and down from zero gives all ones.
- R6: `carry_n` is low exactly when `count` is all ones and the sampled up strobe is low. Otherwise it is high, including after reset.
- R7: `borrow_n` is low exactly when `count` is zero and the sampled down strobe is low. Otherwise it is high, including after reset.
- R8: Two stages chained carry-to-up and borrow-to-down count correctly as one 2×WIDTH-bit counter in both directions, through wrap.
- R9: When both strobes rise in the same sample, or when one strobe rises while the other is low, `count` holds.
- R10: A strobe edge, load or clear shows on `count` exactly SYNC_STAGES+1 system clock edges after the input changes. With the default of two stages, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| up_strobe | input | 1 | Count-up strobe; a rising edge steps up. Idles high |
| dn_strobe | input | 1 | Count-down strobe; a rising edge steps down. Idles high |
| load_n | input | 1 | Active-low parallel load, level-sensitive |
| clear | input | 1 | Active-high clear, level-sensitive; overrides load |
| preset | input | WIDTH | Value loaded while `load_n` is low |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low up terminal count |
| borrow_n | output | 1 | Active-low down terminal count |

## Verification
The bench sweeps every preset value and steps it both up and down, and it drives the count through wrap in each direction. A design that handled the wrap in only one direction would show 16 or -1 truncated wrongly, or would stall at the ends.

The bench also checks the following cases, and what a wrong design would do in each:
- **Clear together with load.** A design with the wrong priority would show the preset where zero is expected.
- **Strobe edges while load is held.** A design that let a step win over load would drift away from the preset.
- **Both strobes rising together, and one strobe rising while the other is low.** A careless decoder would step the count here.
- **Exact latency.** The bench samples the cycle before and the cycle of the update, which catches an extra or a missing pipeline stage.
- **Two-stage chain through 255 and 0.** This exposes a terminal output that pulses on the wrong strobe phase: the upper digit would advance a full pulse early, or not at all.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Decoded action of one sample of the strobe pair
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/dsc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level inputs.
module dsc_sync #(
  parameter int                N       = 4,
  parameter int                STAGES  = 2,
  parameter logic [N-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [N-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= g_stage[g-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/dsc_step.sv
// Rising-edge detector for the strobe pair. It steps only when the other strobe is steadily high.
module dsc_step
  import dsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_e step
);
  logic up_prev, dn_prev;
  logic up_rise, dn_rise, up_steady, dn_steady;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  always_comb begin
    up_rise   = up_lvl & ~up_prev;
    dn_rise   = dn_lvl & ~dn_prev;
    up_steady = up_lvl & up_prev;
    dn_steady = dn_lvl & dn_prev;
    if (up_rise && dn_steady)      step = STEP_UP;
    else if (dn_rise && up_steady) step = STEP_DN;
    else                           step = STEP_NONE;
  end
endmodule

// File: rtl/dsc_core.sv
// Count register: clear beats load, and load beats a step.
module dsc_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  input  step_e            step,
  output logic [WIDTH-1:0] cnt_nxt,
  output logic [WIDTH-1:0] cnt
);
  always_comb begin
    if (clr)                  cnt_nxt = '0;
    else if (!ld_n)           cnt_nxt = preset;
    else if (step == STEP_UP) cnt_nxt = cnt + WIDTH'(1);
    else if (step == STEP_DN) cnt_nxt = cnt - WIDTH'(1);
    else                      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/dsc_term.sv
// Registered terminal-count outputs, aligned with the count register.
module dsc_term #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= ~((cnt_nxt == TOP) & ~up_lvl);
      borrow_n <= ~((cnt_nxt == '0) & ~dn_lvl);
    end
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int NCTL = 4;
  // Bit order {clear, load_n, dn, up}; idle values are used as the reset values
  localparam logic [NCTL-1:0] CTL_IDLE = 4'b0111;

  logic [NCTL-1:0]  ctl_s;
  logic             up_s, dn_s, ld_s_n, clr_s;
  step_e            step;
  logic [WIDTH-1:0] cnt_nxt;

  dsc_sync #(.N(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clear, load_n, dn_strobe, up_strobe}),
    .q   (ctl_s)
  );

  assign {clr_s, ld_s_n, dn_s, up_s} = ctl_s;

  dsc_step u_step (
    .clk    (clk),
    .rst    (rst),
    .up_lvl (up_s),
    .dn_lvl (dn_s),
    .step   (step)
  );

  dsc_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_s),
    .ld_n    (ld_s_n),
    .preset  (preset),
    .step    (step),
    .cnt_nxt (cnt_nxt),
    .cnt     (count)
  );

  dsc_term #(.WIDTH(WIDTH)) u_term (
    .clk      (clk),
    .rst      (rst),
    .cnt_nxt  (cnt_nxt),
    .up_lvl   (up_s),
    .dn_lvl   (dn_s),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_s,
  input logic             ld_s_n,
  input logic [WIDTH-1:0] preset,
  input step_e            step,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  p_up_r1: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_UP && !clr_s && ld_s_n) |=> count == WIDTH'($past(count) + WIDTH'(1)));

  p_dn_r2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_DN && !clr_s && ld_s_n) |=> count == WIDTH'($past(count) - WIDTH'(1)));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_s_n && !clr_s) |=> count == $past(preset));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> count == '0);

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_UP && !clr_s && ld_s_n && count == TOP) |=> count == '0);

  p_carry_r6: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> count == TOP);

  p_borrow_r7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> count == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_NONE && !clr_s && ld_s_n) |=> $stable(count));
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_s    (clr_s),
  .ld_s_n   (ld_s_n),
  .preset   (preset),
  .step     (step),
  .count    (count),
  .carry_n  (carry_n),
  .borrow_n (borrow_n)
);

// File: tb/tb_dual_strobe_counter.sv
module tb_dual_strobe_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MODV = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up_strobe = 1'b1, dn_strobe = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count, hi_count;
  logic         carry_n, borrow_n, hi_carry_n, hi_borrow_n;

  int n_chk = 0, n_fail = 0;
  int m = 0, cm = 0;
  bit casc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_strobe_counter #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .up_strobe(up_strobe), .dn_strobe(dn_strobe),
    .load_n(load_n), .clear(clear), .preset(preset),
    .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  dual_strobe_counter #(.WIDTH(W)) dut_hi (
    .clk(clk), .rst(rst), .up_strobe(carry_n), .dn_strobe(borrow_n),
    .load_n(1'b1), .clear(1'b0), .preset('0),
    .count(hi_count), .carry_n(hi_carry_n), .borrow_n(hi_borrow_n)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_up();
    up_strobe = 1'b0;
    tick(6);
    check("R6 carry", int'(carry_n), (m == MODV-1) ? 0 : 1);
    check("R7 borrow idle", int'(borrow_n), 1);
    up_strobe = 1'b1;
    tick(2);
    check("R10 before update", int'(count), m);
    tick(1);
    check((m == MODV-1) ? "R5 wrap up" : "R1 increment", int'(count), (m + 1) % MODV);
    m  = (m + 1) % MODV;
    cm = (cm + 1) % (MODV*MODV);
    tick(7);
    if (casc) check("R8 cascade up", int'({hi_count, count}), cm);
  endtask

  task automatic pulse_dn();
    dn_strobe = 1'b0;
    tick(6);
    check("R7 borrow", int'(borrow_n), (m == 0) ? 0 : 1);
    check("R6 carry idle", int'(carry_n), 1);
    dn_strobe = 1'b1;
    tick(2);
    check("R10 before update", int'(count), m);
    tick(1);
    check((m == 0) ? "R5 wrap down" : "R2 decrement", int'(count), (m + MODV - 1) % MODV);
    m  = (m + MODV - 1) % MODV;
    cm = (cm + MODV*MODV - 1) % (MODV*MODV);
    tick(7);
    if (casc) check("R8 cascade down", int'({hi_count, count}), cm);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R4 reset count", int'(count), 0);
    check("R6 reset idle", int'(carry_n), 1);
    check("R7 reset idle", int'(borrow_n), 1);

    for (int i = 0; i < 20; i++) pulse_up();
    for (int i = 0; i < 40; i++) pulse_dn();

    // R3: every preset value, held load blocks steps, then steps from it
    for (int p = 0; p < MODV; p++) begin
      preset = W'(p);
      load_n = 1'b0;
      tick(2);
      check("R10 load latency", int'(count), m);
      tick(1);
      check("R3 load", int'(count), p);
      up_strobe = 1'b0; tick(4); up_strobe = 1'b1; tick(6);
      check("R3 held load ignores up", int'(count), p);
      dn_strobe = 1'b0; tick(4); dn_strobe = 1'b1; tick(6);
      check("R3 held load ignores down", int'(count), p);
      load_n = 1'b1;
      tick(4);
      m = p;
      pulse_up();
      pulse_dn();
      pulse_dn();
    end

    // R4: clear overrides load
    preset = W'(9);
    load_n = 1'b0;
    clear  = 1'b1;
    tick(4);
    check("R4 clear over load", int'(count), 0);
    clear = 1'b0;
    tick(4);
    check("R3 load after clear", int'(count), 9);
    load_n = 1'b1;
    tick(4);
    m = 9;
    pulse_up();
    clear = 1'b1;
    tick(4);
    check("R4 clear", int'(count), 0);
    up_strobe = 1'b0; tick(4); up_strobe = 1'b1; tick(6);
    check("R4 clear ignores up", int'(count), 0);
    clear = 1'b0;
    tick(4);
    m = 0;
    pulse_up();
    pulse_up();

    // R9: simultaneous edges, and an edge while the other strobe is low
    up_strobe = 1'b0; dn_strobe = 1'b0;
    tick(6);
    up_strobe = 1'b1; dn_strobe = 1'b1;
    tick(8);
    check("R9 both rise hold", int'(count), m);
    dn_strobe = 1'b0;
    tick(6);
    up_strobe = 1'b0; tick(6); up_strobe = 1'b1; tick(8);
    check("R9 up while down low hold", int'(count), m);
    dn_strobe = 1'b1;
    tick(8);
    m = (m + MODV - 1) % MODV;
    check("R2 down rise with up high", int'(count), m);

    // R8: two-stage chain
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(4);
    m = 0; cm = 0; casc = 1;
    check("R8 chain reset", int'({hi_count, count}), 0);
    for (int i = 0; i < 300; i++) pulse_up();
    for (int i = 0; i < 600; i++) pulse_dn();

    summary();
    $finish;
  end
endmodule